// File: doc/BRIEF.md
# Serial Channel Character Buffer with Selectable Request Levels

This block holds the characters of one serial channel on their way between a host register interface and the bit-level engines. The host writes transmit characters into a transmit queue. A serializer takes them out one at a time, oldest first. A deserializer pushes received characters into a receive queue, and the host reads them out through a show-ahead data port.

Two request lines tell the host when to service the channel. Each has a trigger level that the host selects:

- **Transmit request:** fires on any free slot, or only once the queue has fully drained.
- **Receive request:** fires on every received character, or only once the queue is half full.

A compatibility mode shrinks both queues to a single-character holding register. A received character that finds the queue full is dropped and latches a sticky overrun flag. A one-cycle command silences the pending transmit request.

Top module: `sio_fifo_buf`

## Requirements
- R1: With `compat_mode` low, the transmit queue accepts 4 characters and the receive queue accepts 8. Both deliver characters in arrival order. The transmit head is shown on `ser_data` while `ser_valid` is high. The receive head is shown on `host_rd_data`.
- R2: With `compat_mode` high, each queue holds at most one character.
- R3: A host write while the transmit queue is at capacity is dropped. Queue contents, order and `tx_req` are unchanged.
- R4: With `tx_drain_lvl` low, `tx_req` is high whenever the transmit queue holds fewer characters than its capacity.
- R5: With `tx_drain_lvl` high, `tx_req` is high only while the transmit queue is empty.
- R6: A `tx_req_clr` pulse forces `tx_req` low from the next cycle. It stays low while the trigger condition remains true. It rises again only after the condition has gone false and become true once more.
- R7: With `rx_half_lvl` low (or in compatibility mode), `rx_req` is high whenever at least one character is waiting.
- R8: With `rx_half_lvl` high in normal mode, `rx_req` is high only while at least 4 characters (half of 8) are waiting. It drops as soon as the level falls below 4.
- R9: A deserializer character arriving while the receive queue is at capacity is discarded. The stored characters are kept intact.
- R10: `rx_status` bit 5 is a sticky overrun flag. A discard (R9) sets it, and only `err_clr` or reset clears it; when both occur together, the set wins. `rx_status` bit 0 is high while a receive character is waiting. All other bits read 0.
- R11: After reset both queues are empty, `tx_req` is 1, `rx_req` is 0, `ser_valid` is 0 and `rx_status` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compat_mode | input | 1 | 1: single-character holding registers |
| tx_drain_lvl | input | 1 | 1: transmit request only when fully drained |
| rx_half_lvl | input | 1 | 1: receive request at half full |
| host_wr_en | input | 1 | Host write strobe for a transmit character |
| host_wr_data | input | 8 | Transmit character |
| host_rd_en | input | 1 | Host read strobe, pops the receive head |
| host_rd_data | output | 8 | Receive head character |
| tx_req_clr | input | 1 | Command: clear the pending transmit request |
| err_clr | input | 1 | Command: clear the overrun flag |
| ser_ready | input | 1 | Serializer takes the head when `ser_valid` is high |
| ser_valid | output | 1 | Transmit queue not empty |
| ser_data | output | 8 | Transmit head character |
| des_valid | input | 1 | Deserializer delivers a character |
| des_data | input | 8 | Received character |
| rx_status | output | 8 | Bit 5 overrun (sticky), bit 0 character available |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |

## Verification
The bench fills the transmit queue past its capacity. A design that let the extra write through would show a fifth character on the serializer port or would corrupt the head. It also overfills the receive queue in both modes: a wrong design would overwrite stored characters or miss the sticky flag. After a clear command, the transmit request is held through a period in which the trigger stays true, then re-armed. A design that re-raised it at once, or never re-raised it, is caught on the cycle it misbehaves. Switching the receive level while three characters wait exposes a threshold that is compared with the wrong bound or kept in a stale register.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic {
        TXTRIG_FREE_SLOT = 1'b0,
        TXTRIG_DRAINED   = 1'b1
    } tx_trig_e;

    typedef enum logic {
        RXTRIG_EACH = 1'b0,
        RXTRIG_HALF = 1'b1
    } rx_trig_e;

    // bit 5 overrun, bit 0 available
    typedef struct packed {
        logic [1:0] rsvd_hi;
        logic       overrun;
        logic [3:0] rsvd_lo;
        logic       avail;
    } rx_stat_t;

    function automatic int unsigned lvl_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int unsigned ptr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo
    import sio_fifo_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = ptr_width(DEPTH),
    localparam int unsigned CW   = lvl_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          dropped
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dropped = push & full;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/sio_tx_req_ctl.sv
module sio_tx_req_ctl
    import sio_fifo_pkg::*;
#(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] cap,
    input  tx_trig_e      trig,
    input  logic          clr_cmd,
    output logic          req
);

    logic cond;
    logic muted_q;

    always_comb begin
        unique case (trig)
            TXTRIG_DRAINED:   cond = (count == '0);
            TXTRIG_FREE_SLOT: cond = (count < cap);
            default:          cond = 1'b0;
        endcase
    end

    // mute holds while the trigger stays true; re-arms once it goes false
    always_ff @(posedge clk) begin
        if (rst) begin
            muted_q <= 1'b0;
        end else if (clr_cmd) begin
            muted_q <= 1'b1;
        end else if (!cond) begin
            muted_q <= 1'b0;
        end
    end

    assign req = cond & ~muted_q;

endmodule

// File: rtl/sio_rx_req_ctl.sv
module sio_rx_req_ctl
    import sio_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = lvl_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic          compat,
    input  rx_trig_e      trig,
    input  logic          dropped,
    input  logic          err_clr,
    output logic          req,
    output logic          overrun
);

    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic [CW-1:0] thresh;

    always_comb begin
        if (compat || trig == RXTRIG_EACH) begin
            thresh = CW'(1);
        end else begin
            thresh = HALF;
        end
    end

    assign req = (count >= thresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (dropped) begin
            overrun <= 1'b1;
        end else if (err_clr) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_fifo_buf.sv
module sio_fifo_buf
    import sio_fifo_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 4,
    parameter int unsigned RX_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       compat_mode,
    input  logic       tx_drain_lvl,
    input  logic       rx_half_lvl,
    input  logic       host_wr_en,
    input  logic [7:0] host_wr_data,
    input  logic       host_rd_en,
    output logic [7:0] host_rd_data,
    input  logic       tx_req_clr,
    input  logic       err_clr,
    input  logic       ser_ready,
    output logic       ser_valid,
    output logic [7:0] ser_data,
    input  logic       des_valid,
    input  logic [7:0] des_data,
    output logic [7:0] rx_status,
    output logic       tx_req,
    output logic       rx_req
);

    localparam int unsigned TXCW = lvl_width(TX_DEPTH);
    localparam int unsigned RXCW = lvl_width(RX_DEPTH);

    logic [TXCW-1:0] tx_cap, tx_cnt;
    logic [RXCW-1:0] rx_cap, rx_cnt;
    logic            tx_full, tx_empty, tx_drop;
    logic            rx_full, rx_empty, rx_drop;
    logic            ser_take;
    logic            ovr;
    char_t           tx_head, rx_head;
    rx_stat_t        stat;

    assign tx_cap = compat_mode ? TXCW'(1) : TXCW'(TX_DEPTH);
    assign rx_cap = compat_mode ? RXCW'(1) : RXCW'(RX_DEPTH);

    assign ser_take = ser_ready & ~tx_empty;

    sio_byte_fifo #(.W(CHAR_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .cap     (tx_cap),
        .push    (host_wr_en),
        .din     (host_wr_data),
        .pop     (ser_take),
        .dout    (tx_head),
        .count   (tx_cnt),
        .full    (tx_full),
        .empty   (tx_empty),
        .dropped (tx_drop)
    );

    sio_byte_fifo #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .cap     (rx_cap),
        .push    (des_valid),
        .din     (des_data),
        .pop     (host_rd_en),
        .dout    (rx_head),
        .count   (rx_cnt),
        .full    (rx_full),
        .empty   (rx_empty),
        .dropped (rx_drop)
    );

    sio_tx_req_ctl #(.CW(TXCW)) u_txreq (
        .clk     (clk),
        .rst     (rst),
        .count   (tx_cnt),
        .cap     (tx_cap),
        .trig    (tx_trig_e'(tx_drain_lvl)),
        .clr_cmd (tx_req_clr),
        .req     (tx_req)
    );

    sio_rx_req_ctl #(.DEPTH(RX_DEPTH)) u_rxreq (
        .clk     (clk),
        .rst     (rst),
        .count   (rx_cnt),
        .compat  (compat_mode),
        .trig    (rx_trig_e'(rx_half_lvl)),
        .dropped (rx_drop),
        .err_clr (err_clr),
        .req     (rx_req),
        .overrun (ovr)
    );

    always_comb begin
        stat         = '0;
        stat.overrun = ovr;
        stat.avail   = ~rx_empty;
    end

    assign rx_status    = stat;
    assign ser_valid    = ~tx_empty;
    assign ser_data     = tx_head;
    assign host_rd_data = rx_head;

endmodule

// File: rtl/sio_fifo_buf_chk.sv
module sio_fifo_buf_chk #(
    parameter int unsigned TX_DEPTH = 4,
    parameter int unsigned RX_DEPTH = 8,
    localparam int unsigned TXCW    = $clog2(TX_DEPTH + 1),
    localparam int unsigned RXCW    = $clog2(RX_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            compat_mode,
    input logic            host_wr_en,
    input logic            host_rd_en,
    input logic            ser_ready,
    input logic            ser_valid,
    input logic            des_valid,
    input logic            tx_req_clr,
    input logic            err_clr,
    input logic [7:0]      rx_status,
    input logic            tx_req,
    input logic            rx_req,
    input logic [TXCW-1:0] tx_cnt,
    input logic [RXCW-1:0] rx_cnt
);

    logic [TXCW-1:0] tcap;
    logic [RXCW-1:0] rcap;
    assign tcap = compat_mode ? TXCW'(1) : TXCW'(TX_DEPTH);
    assign rcap = compat_mode ? RXCW'(1) : RXCW'(RX_DEPTH);

    // R1
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= TXCW'(TX_DEPTH)) && (rx_cnt <= RXCW'(RX_DEPTH)));

    // R3
    tx_full_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && tx_cnt == tcap && !(ser_ready && ser_valid)) |=> $stable(tx_cnt));

    // R6
    tx_clr_mutes_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req_clr |=> !tx_req);

    // R7
    rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == '0) |-> !rx_req);

    // R9
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (des_valid && rx_cnt == rcap && !host_rd_en) |=> ($stable(rx_cnt) && rx_status[5]));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_status[5] && !err_clr) |=> rx_status[5]);

endmodule

bind sio_fifo_buf sio_fifo_buf_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .compat_mode (compat_mode),
    .host_wr_en  (host_wr_en),
    .host_rd_en  (host_rd_en),
    .ser_ready   (ser_ready),
    .ser_valid   (ser_valid),
    .des_valid   (des_valid),
    .tx_req_clr  (tx_req_clr),
    .err_clr     (err_clr),
    .rx_status   (rx_status),
    .tx_req      (tx_req),
    .rx_req      (rx_req),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt)
);

// File: tb/sim_sio_fifo_buf.sv
module sim_sio_fifo_buf;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 19;

    // [14] tx_drain_lvl [13] rx_half_lvl [12:10] op [9:2] data [1] exp tx_req [0] exp rx_req
    // op: 0 idle, 1 host write, 2 serializer take, 3 deserializer push, 4 host read, 5 tx clear
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 3'd1, 8'hA1, 1'b1, 1'b0},
        {1'b0, 1'b0, 3'd1, 8'hA2, 1'b1, 1'b0},
        {1'b0, 1'b0, 3'd1, 8'hA3, 1'b1, 1'b0},
        {1'b0, 1'b0, 3'd1, 8'hA4, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd3, 8'hB0, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd3, 8'hB1, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd3, 8'hB2, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd3, 8'hB3, 1'b1, 1'b1},
        {1'b1, 1'b1, 3'd4, 8'h00, 1'b1, 1'b0},
        {1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1},
        {1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 1'b1},
        {1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1},
        {1'b1, 1'b0, 3'd1, 8'hC0, 1'b0, 1'b1},
        {1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       compat_mode = 1'b0, tx_drain_lvl = 1'b0, rx_half_lvl = 1'b0;
    logic       host_wr_en = 1'b0, host_rd_en = 1'b0, tx_req_clr = 1'b0, err_clr = 1'b0;
    logic       ser_ready = 1'b0, des_valid = 1'b0;
    logic [7:0] host_wr_data = '0, des_data = '0;
    logic [7:0] host_rd_data, ser_data, rx_status;
    logic       ser_valid, tx_req, rx_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sio_fifo_buf u0 (
        .clk          (clk),
        .rst          (rst),
        .compat_mode  (compat_mode),
        .tx_drain_lvl (tx_drain_lvl),
        .rx_half_lvl  (rx_half_lvl),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_en   (host_rd_en),
        .host_rd_data (host_rd_data),
        .tx_req_clr   (tx_req_clr),
        .err_clr      (err_clr),
        .ser_ready    (ser_ready),
        .ser_valid    (ser_valid),
        .ser_data     (ser_data),
        .des_valid    (des_valid),
        .des_data     (des_data),
        .rx_status    (rx_status),
        .tx_req       (tx_req),
        .rx_req       (rx_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        host_wr_en   = (op == 3'd1);
        host_wr_data = d;
        ser_ready    = (op == 3'd2);
        des_valid    = (op == 3'd3);
        des_data     = d;
        host_rd_en   = (op == 3'd4);
        tx_req_clr   = (op == 3'd5);
        @(posedge clk);
        @(negedge clk);
        host_wr_en = 1'b0; ser_ready = 1'b0; des_valid = 1'b0;
        host_rd_en = 1'b0; tx_req_clr = 1'b0; err_clr = 1'b0;
        #1;
    endtask

    task automatic do_reset(input logic compat);
        @(negedge clk);
        rst = 1'b1;
        compat_mode = compat; tx_drain_lvl = 1'b0; rx_half_lvl = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset(1'b0);
        check("R11 tx_req", {7'd0, tx_req}, 8'd1);
        check("R11 rx_req", {7'd0, rx_req}, 8'd0);
        check("R11 ser_valid", {7'd0, ser_valid}, 8'd0);
        check("R11 rx_status", rx_status, 8'h00);

        // table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            tx_drain_lvl = VEC[i][14];
            rx_half_lvl  = VEC[i][13];
            do_op(VEC[i][12:10], VEC[i][9:2]);
            check($sformatf("R4/R5/R6 tx_req row %0d", i), {7'd0, tx_req}, {7'd0, VEC[i][1]});
            check($sformatf("R7/R8 rx_req row %0d", i), {7'd0, rx_req}, {7'd0, VEC[i][0]});
        end

        // R1 R3: normal mode depth, order, write to full ignored
        do_reset(1'b0);
        for (int k = 0; k < 5; k++) do_op(3'd1, 8'h10 + 8'(k));
        check("R3 tx_req at full", {7'd0, tx_req}, 8'd0);
        for (int k = 0; k < 4; k++) begin
            check("R1 R3 tx order", ser_data, 8'h10 + 8'(k));
            do_op(3'd2, 8'h00);
        end
        check("R3 extra write absent", {7'd0, ser_valid}, 8'd0);

        // R1 R9 R10: receive fill, overflow, order
        for (int k = 0; k < 8; k++) do_op(3'd3, 8'h20 + 8'(k));
        check("R10 no overrun yet", rx_status, 8'h01);
        do_op(3'd3, 8'h99);
        check("R9 R10 overrun set", rx_status, 8'h21);
        for (int k = 0; k < 8; k++) begin
            check("R1 R9 rx order", host_rd_data, 8'h20 + 8'(k));
            do_op(3'd4, 8'h00);
        end
        check("R9 R10 empty sticky", rx_status, 8'h20);
        err_clr = 1'b1;
        do_op(3'd0, 8'h00);
        check("R10 err_clr", rx_status, 8'h00);

        // R2: compatibility mode
        do_reset(1'b1);
        do_op(3'd1, 8'h40);
        check("R2 tx one deep req", {7'd0, tx_req}, 8'd0);
        do_op(3'd1, 8'h41);
        check("R2 tx head", ser_data, 8'h40);
        do_op(3'd2, 8'h00);
        check("R2 tx drained", {7'd0, ser_valid}, 8'd0);
        rx_half_lvl = 1'b1;
        do_op(3'd3, 8'h50);
        check("R2 R7 rx req one byte", {7'd0, rx_req}, 8'd1);
        do_op(3'd3, 8'h51);
        check("R2 R10 overrun", rx_status, 8'h21);
        check("R2 R9 rx kept", host_rd_data, 8'h50);
        do_op(3'd4, 8'h00);
        check("R2 rx empty", rx_status, 8'h20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule